// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the command front end of a parallel NOR flash device. It watches host write cycles (address, data byte, write strobe) and keeps the device mode. Two unlock writes followed by a command byte open the identification mode. A six-write sequence starts a sector erase. Single writes suspend, resume and reset, and these are accepted at any address. While identification mode is active, host reads return the maker code, the device code or a per-sector protection flag. These codes come from constants and from an input vector, never from the storage array.

The erase engine sits outside the block and is reached through a small handshake. A one-cycle `erase_start` pulse carries the target sector. A level output `erase_run` tells the engine to advance. The engine answers with `erase_done`. Suspending an erase drops `erase_run` and keeps the target sector. Identification mode can also be opened while an erase is suspended. Leaving it then returns to the suspended erase, not to plain array reads.

The five modes are READ (array read), IDENT (identification), ERASING, SUSPENDED and SUSP_IDENT (identification opened from SUSPENDED). The transitions are:
- READ→IDENT on the identification sequence.
- READ→ERASING on the erase sequence.
- IDENT→READ on reset.
- ERASING→READ on `erase_done`.
- ERASING→SUSPENDED on suspend.
- SUSPENDED→ERASING on resume.
- SUSPENDED→SUSP_IDENT on the identification sequence.
- SUSP_IDENT→SUSPENDED on reset.

Any other event leaves the mode as it is.

Top module: `flash_cmd_fsm`

## Requirements
- R1: The writes 0x555/0xAA, then 0x2AA/0x55, then 0x555/0x90 on the low 11 address bits, issued in READ, put the block into IDENT. `id_mode` is high in the cycle after the third write.
- R2: A write whose address or data does not match the next expected step aborts the sequence and leaves the mode unchanged. A later third-step byte on its own then has no effect.
- R3: A read (`rd_en`) in an identification mode gives `rd_id_valid`=1 one cycle later. Low address byte 0x00, 0x04, 0x08 or 0x0C returns MAKER_ID, 0x01 returns DEVICE_ID, and any other low byte except 0x02 returns 0x00. This holds for any number of reads with no further command.
- R4: A read with low byte 0x02 returns 0x01 when `sect_prot` bit s is set and 0x00 when it is clear. Here s is the sector field held in the top SECT_W address bits.
- R5: Writing data 0xF0 at any address in IDENT returns the block to READ.
- R6: In READ, the sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then data 0x30 at an address in sector s enters ERASING. `erase_start` is high for exactly one cycle with `erase_sector`=s, and `erase_run` stays high. Unlock sequences written while ERASING have no effect.
- R7: Data 0xB0 at any address while ERASING enters SUSPENDED: `erase_run` low and `erase_susp` high.
- R8: Data 0x30 at any address in SUSPENDED resumes the erase, with `erase_run` high and no new `erase_start`. A further 0x30 while ERASING is ignored. A new 0xB0 after resuming suspends again.
- R9: The identification sequence in SUSPENDED enters SUSP_IDENT, with codes readable even inside the sector being erased. Reset (0xF0) then returns to SUSPENDED, not to READ.
- R10: `erase_done` while ERASING returns the block to READ. `erase_done` in any other mode is ignored.
- R11: A read outside identification mode gives `rd_id_valid`=0 and `rdata`=0x00 one cycle later.
- R12: After reset the mode is READ: `id_mode`, `erase_run`, `erase_susp`, `erase_start` and `rd_id_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| addr | input | ADDR_W | Host address: low 11 bits for unlock, top SECT_W bits for the sector |
| wdata | input | 8 | Host write data byte |
| rd_en | input | 1 | Host read strobe |
| sect_prot | input | 2**SECT_W | Protection flag per sector |
| erase_done | input | 1 | Erase engine has finished |
| rdata | output | 8 | Identification code, valid with rd_id_valid |
| rd_id_valid | output | 1 | Read served from identification codes |
| id_mode | output | 1 | An identification mode is active |
| erase_run | output | 1 | Erase engine may advance |
| erase_susp | output | 1 | Erase is suspended |
| erase_start | output | 1 | One-cycle erase launch pulse |
| erase_sector | output | SECT_W | Sector targeted by the erase |

## Verification
The bench targets sequences that go wrong in one write. It sends an unlock with a wrong address, which a careless decoder would still accept and so enter identification mode. It sends 0x30 twice: a decoder that does not separate resume from the erase confirm byte would restart the erase or pulse `erase_start` again. It opens identification from a suspended erase and then resets; a design that forgets where it came from would drop into READ and lose the erase. It also reads the maker aliases, the protection flags of set and clear sectors, and codes inside the sector under erase. A decode error there would return the wrong byte. Finally it raises `erase_done` outside ERASING, which must not disturb identification mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        M_READ,
        M_IDENT,
        M_ERASING,
        M_SUSPENDED,
        M_SUSP_IDENT
    } mode_t;

    typedef enum logic [2:0] {
        Q_IDLE,
        Q_KEY1,
        Q_KEY2,
        Q_ARMED,
        Q_AKEY1,
        Q_AKEY2
    } seq_t;

    typedef struct packed {
        logic reset;
        logic suspend;
        logic resume;
        logic ident;
        logic erase;
    } cmd_ev_t;

    localparam int          UNLK_W     = 11;
    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  OP_IDENT   = 8'h90;
    localparam logic [7:0]  OP_ARM     = 8'h80;
    localparam logic [7:0]  OP_CONFIRM = 8'h30;
    localparam logic [7:0]  OP_RESUME  = 8'h30;
    localparam logic [7:0]  OP_SUSPEND = 8'hB0;
    localparam logic [7:0]  OP_RESET   = 8'hF0;

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
    import flash_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [UNLK_W-1:0]   addr_lo,
    input  logic [7:0]          wdata,
    output cmd_ev_t             ev
);

    seq_t st_q, st_d;

    logic hit_a;
    logic hit_b;

    assign hit_a = (addr_lo == KEY_ADDR_A) && (wdata == KEY_DATA_A);
    assign hit_b = (addr_lo == KEY_ADDR_B) && (wdata == KEY_DATA_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= Q_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        ev   = '0;
        if (wr_en) begin
            if (wdata == OP_RESET) begin
                ev.reset = 1'b1;
                st_d     = Q_IDLE;
            end else if (wdata == OP_SUSPEND) begin
                ev.suspend = 1'b1;
                st_d       = Q_IDLE;
            end else if (wdata == OP_RESUME && st_q != Q_AKEY2) begin
                ev.resume = 1'b1;
                st_d      = Q_IDLE;
            end else begin
                unique case (st_q)
                    Q_IDLE: begin
                        st_d = hit_a ? Q_KEY1 : Q_IDLE;
                    end
                    Q_KEY1: begin
                        st_d = hit_b ? Q_KEY2 : Q_IDLE;
                    end
                    Q_KEY2: begin
                        st_d = Q_IDLE;
                        if (addr_lo == KEY_ADDR_A && wdata == OP_IDENT) begin
                            ev.ident = 1'b1;
                        end else if (addr_lo == KEY_ADDR_A && wdata == OP_ARM) begin
                            st_d = Q_ARMED;
                        end
                    end
                    Q_ARMED: begin
                        st_d = hit_a ? Q_AKEY1 : Q_IDLE;
                    end
                    Q_AKEY1: begin
                        st_d = hit_b ? Q_AKEY2 : Q_IDLE;
                    end
                    Q_AKEY2: begin
                        st_d = Q_IDLE;
                        if (wdata == OP_CONFIRM) begin
                            ev.erase = 1'b1;
                        end
                    end
                    default: begin
                        st_d = Q_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_id_read.sv
module flash_id_read #(
    parameter int          SECT_W    = 4,
    parameter logic [7:0]  MAKER_ID  = 8'h7F,
    parameter logic [7:0]  DEVICE_ID = 8'h5B
) (
    input  logic [7:0]             lo_byte,
    input  logic [SECT_W-1:0]      sector,
    input  logic [(1<<SECT_W)-1:0] sect_prot,
    output logic [7:0]             code
);

    always_comb begin
        case (lo_byte)
            8'h00, 8'h04, 8'h08, 8'h0C: code = MAKER_ID;
            8'h01:                      code = DEVICE_ID;
            8'h02:                      code = {7'b0, sect_prot[sector]};
            default:                    code = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 15,
    parameter int          SECT_W    = 4,
    parameter logic [7:0]  MAKER_ID  = 8'h7F,
    parameter logic [7:0]  DEVICE_ID = 8'h5B
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    input  logic                     rd_en,
    input  logic [(1<<SECT_W)-1:0]   sect_prot,
    input  logic                     erase_done,
    output logic [7:0]               rdata,
    output logic                     rd_id_valid,
    output logic                     id_mode,
    output logic                     erase_run,
    output logic                     erase_susp,
    output logic                     erase_start,
    output logic [SECT_W-1:0]        erase_sector
);

    localparam int N_SECT = 1 << SECT_W;
    localparam int SEC_LO = ADDR_W - SECT_W;

    mode_t             mode_q, mode_d;
    cmd_ev_t           ev;
    logic [SECT_W-1:0] sec_field;
    logic [7:0]        id_code;
    logic              start_q, start_d;
    logic [SECT_W-1:0] sector_q;
    logic              rvalid_q;
    logic [7:0]        rdata_q;

    assign sec_field = addr[ADDR_W-1:SEC_LO];

    flash_seq_decode u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr_lo (addr[UNLK_W-1:0]),
        .wdata   (wdata),
        .ev      (ev)
    );

    flash_id_read #(
        .SECT_W    (SECT_W),
        .MAKER_ID  (MAKER_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_id (
        .lo_byte   (addr[7:0]),
        .sector    (sec_field),
        .sect_prot (sect_prot[N_SECT-1:0]),
        .code      (id_code)
    );

    // next-mode logic
    always_comb begin
        mode_d  = mode_q;
        start_d = 1'b0;
        unique case (mode_q)
            M_READ: begin
                if (ev.ident) begin
                    mode_d = M_IDENT;
                end else if (ev.erase) begin
                    mode_d  = M_ERASING;
                    start_d = 1'b1;
                end
            end
            M_IDENT: begin
                if (ev.reset) mode_d = M_READ;
            end
            M_ERASING: begin
                if (erase_done)      mode_d = M_READ;
                else if (ev.suspend) mode_d = M_SUSPENDED;
            end
            M_SUSPENDED: begin
                if (ev.resume)     mode_d = M_ERASING;
                else if (ev.ident) mode_d = M_SUSP_IDENT;
            end
            M_SUSP_IDENT: begin
                if (ev.reset) mode_d = M_SUSPENDED;
            end
            default: mode_d = M_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= M_READ;
            start_q  <= 1'b0;
            sector_q <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            mode_q   <= mode_d;
            start_q  <= start_d;
            if (start_d) sector_q <= sec_field;
            rvalid_q <= rd_en && id_mode;
            rdata_q  <= (rd_en && id_mode) ? id_code : 8'h00;
        end
    end

    // outputs
    always_comb begin
        id_mode      = (mode_q == M_IDENT) || (mode_q == M_SUSP_IDENT);
        erase_run    = (mode_q == M_ERASING);
        erase_susp   = (mode_q == M_SUSPENDED) || (mode_q == M_SUSP_IDENT);
        erase_start  = start_q;
        erase_sector = sector_q;
        rd_id_valid  = rvalid_q;
        rdata        = rdata_q;
    end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int ADDR_W = 15,
    parameter int SECT_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [7:0]             wdata,
    input logic                   rd_en,
    input logic [(1<<SECT_W)-1:0] sect_prot,
    input logic                   erase_done,
    input logic [7:0]             rdata,
    input logic                   rd_id_valid,
    input logic                   id_mode,
    input logic                   erase_run,
    input logic                   erase_susp,
    input logic                   erase_start
);

    a_r3_valid_after_ident_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id_valid |-> $past(rd_en) && $past(id_mode));

    a_r4_protect_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id_valid && $past(addr[7:0]) == 8'h02)
        |-> rdata == {7'b0, $past(sect_prot[addr[ADDR_W-1 -: SECT_W]])});

    a_r5_reset_leaves_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && !erase_susp && wr_en && wdata == 8'hF0) |=> !id_mode && !erase_susp);

    a_r6_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> erase_run && $past(!erase_run && !erase_susp));

    a_r7_suspend_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && !erase_done && wr_en && wdata == 8'hB0) |=> erase_susp && !erase_run);

    a_r8_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && !erase_done && wr_en && wdata == 8'h30) |=> erase_run && !erase_start);

    a_r9_reset_back_to_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && erase_susp && wr_en && wdata == 8'hF0) |=> erase_susp && !id_mode);

    a_r10_done_ends_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && erase_done) |=> !erase_run && !erase_susp);

    a_r11_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_id_valid |-> rdata == 8'h00);

endmodule

bind flash_cmd_fsm flash_cmd_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rd_en       (rd_en),
    .sect_prot   (sect_prot),
    .erase_done  (erase_done),
    .rdata       (rdata),
    .rd_id_valid (rd_id_valid),
    .id_mode     (id_mode),
    .erase_run   (erase_run),
    .erase_susp  (erase_susp),
    .erase_start (erase_start)
);

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;

    localparam int ADDR_W = 15;
    localparam int SECT_W = 4;
    localparam int NS     = 1 << SECT_W;
    localparam logic [7:0] MK = 8'h7F;
    localparam logic [7:0] DV = 8'h5B;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              rd_en = 1'b0;
    logic [NS-1:0]     sect_prot = 16'hA5A5;
    logic              erase_done = 1'b0;
    logic [7:0]        rdata;
    logic              rd_id_valid, id_mode, erase_run, erase_susp, erase_start;
    logic [SECT_W-1:0] erase_sector;

    int n_chk = 0;
    int n_bad = 0;
    logic rd_q = 1'b0;

    typedef struct {
        logic       v;
        logic [7:0] d;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .MAKER_ID(MK), .DEVICE_ID(DV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .sect_prot(sect_prot), .erase_done(erase_done),
        .rdata(rdata), .rd_id_valid(rd_id_valid), .id_mode(id_mode),
        .erase_run(erase_run), .erase_susp(erase_susp), .erase_start(erase_start),
        .erase_sector(erase_sector)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic v, input logic [7:0] d, input string req);
        exp_t e;
        e.v = v; e.d = d; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ident_seq(input logic [7:0] op);
        wr(15'h0555, 8'hAA);
        wr(15'h02AA, 8'h55);
        wr(15'h0555, op);
    endtask

    function automatic logic [ADDR_W-1:0] sa(input int s, input logic [7:0] lo);
        return ADDR_W'((s << (ADDR_W - SECT_W)) | lo);
    endfunction

    always @(posedge clk) rd_q <= rd_en;

    // monitor: compare read results against the scoreboard
    always @(negedge clk) begin
        if (rd_q) begin
            if (sb.size() == 0) begin
                chk("scoreboard empty", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " valid"}, int'(rd_id_valid), int'(e.v));
                chk({e.req, " data"}, int'(rdata), int'(e.d));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 id_mode", int'(id_mode), 0);
        chk("R12 erase_run", int'(erase_run), 0);
        chk("R12 erase_susp", int'(erase_susp), 0);
        chk("R12 erase_start", int'(erase_start), 0);
        chk("R12 rd_id_valid", int'(rd_id_valid), 0);

        // R11 reads in READ mode are not served
        rd(15'h0000, 1'b0, 8'h00, "R11 array read");

        // R2 aborted sequences
        ident_seq(8'h91);
        chk("R2 wrong op", int'(id_mode), 0);
        wr(15'h0555, 8'hAA); wr(15'h02AB, 8'h55); wr(15'h0555, 8'h90);
        chk("R2 wrong unlock addr", int'(id_mode), 0);

        // R1 entry
        ident_seq(8'h90);
        chk("R1 ident entry", int'(id_mode), 1);

        // R3 codes
        rd(15'h0000, 1'b1, MK, "R3 maker 00");
        rd(15'h0004, 1'b1, MK, "R3 maker 04");
        rd(sa(9, 8'h08), 1'b1, MK, "R3 maker 08");
        rd(15'h000C, 1'b1, MK, "R3 maker 0C");
        rd(15'h0001, 1'b1, DV, "R3 device");
        rd(15'h0003, 1'b1, 8'h00, "R3 other");
        // R4 protection, pattern A5A5
        rd(sa(0, 8'h02), 1'b1, 8'h01, "R4 sector0");
        rd(sa(1, 8'h02), 1'b1, 8'h00, "R4 sector1");
        rd(sa(5, 8'h02), 1'b1, 8'h01, "R4 sector5");
        rd(sa(15, 8'h02), 1'b1, 8'h01, "R4 sector15");

        // R10 erase_done outside ERASING ignored
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        chk("R10 done ignored", int'(id_mode), 1);

        // R5 reset
        wr(15'h0123, 8'hF0);
        chk("R5 reset to read", int'(id_mode), 0);
        rd(15'h0000, 1'b0, 8'h00, "R11 after reset");

        // R6 erase sector 3
        wr(15'h0555, 8'hAA); wr(15'h02AA, 8'h55); wr(15'h0555, 8'h80);
        wr(15'h0555, 8'hAA); wr(15'h02AA, 8'h55); wr(sa(3, 8'h00), 8'h30);
        chk("R6 start pulse", int'(erase_start), 1);
        chk("R6 run", int'(erase_run), 1);
        chk("R6 sector", int'(erase_sector), 3);
        @(negedge clk);
        chk("R6 pulse one cycle", int'(erase_start), 0);
        ident_seq(8'h90);
        chk("R6 ident ignored while erasing", int'(id_mode), 0);
        chk("R6 still running", int'(erase_run), 1);

        // R8 resume while erasing ignored
        wr(15'h0042, 8'h30);
        chk("R8 resume ignored run", int'(erase_run), 1);
        chk("R8 resume ignored start", int'(erase_start), 0);

        // R7 suspend
        wr(15'h7FFF, 8'hB0);
        chk("R7 run low", int'(erase_run), 0);
        chk("R7 susp high", int'(erase_susp), 1);

        // R9 ident from suspend
        ident_seq(8'h90);
        chk("R9 ident", int'(id_mode), 1);
        chk("R9 still susp", int'(erase_susp), 1);
        rd(sa(3, 8'h00), 1'b1, MK, "R9 maker in erased sector");
        rd(sa(3, 8'h02), 1'b1, 8'h00, "R9 protect in erased sector");
        wr(15'h0000, 8'hF0);
        chk("R9 back to susp", int'(erase_susp), 1);
        chk("R9 ident off", int'(id_mode), 0);
        chk("R9 not running", int'(erase_run), 0);

        // R8 resume, repeat, suspend again, resume
        wr(15'h1234, 8'h30);
        chk("R8 resume run", int'(erase_run), 1);
        chk("R8 resume no start", int'(erase_start), 0);
        wr(15'h0555, 8'h30);
        chk("R8 repeat resume", int'(erase_run), 1);
        wr(15'h0000, 8'hB0);
        chk("R8 resuspend", int'(erase_susp), 1);
        wr(15'h0000, 8'h30);
        chk("R8 resume again", int'(erase_run), 1);
        chk("R8 sector kept", int'(erase_sector), 3);

        // R10 done
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        chk("R10 run off", int'(erase_run), 0);
        chk("R10 susp off", int'(erase_susp), 0);
        ident_seq(8'h90);
        chk("R10 read mode accepts ident", int'(id_mode), 1);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule